// File: doc/BRIEF.md
# Carry-save Montgomery modular multiplier

This block multiplies two operands modulo an odd modulus in Montgomery form: it returns a value congruent to X·Y·2^-n mod N, where n is the operand width. One bit of X is consumed per clock, least significant first. There are n+2 processing elements in a single row, and the row is reused by feeding its outputs back to its inputs. The running total is kept as a pair of words, one carry and one sum, and is never resolved to binary inside the loop. The element at bit zero also works out the quotient bit of the iteration. Each iteration adds exactly one addend, chosen from 0, N, Y or the precomputed Y+N, with a three-input carry-save addition. The total is then halved.

The final conditional subtraction is left out. The result is therefore unreduced but stays below 2N, and it can be fed straight back as an operand when the modulus satisfies 4N < 2^n. A one-cycle start pulse loads the operands and clears the accumulator. A one-cycle done pulse marks the result. The carry and sum words then hold until the next start. Adding the two words and reducing modulo N is left to the consumer.

Top module: `mm_cs_montmul`

## Requirements
- R1: While reset is high and in the cycle after it, done is low and both result words are zero.
- R2: With N odd, 4N < 2^n, X and Y below 2N and the Y+N input equal to Y+N, the sum of the carry word and the sum word is congruent to X·Y·2^-n modulo N.
- R3: Under the same conditions the sum of the two result words is below 2N, so no final subtraction is applied.
- R4: If start is sampled high at clock edge E0, done is high only in the cycle after edge E0+n. It lasts exactly one cycle, and the iteration counter never passes n-1.
- R5: After done, the carry and sum words hold their values and done stays low until the next start.
- R6: A start during a running operation discards that operation and loads the new operands. Done comes n cycles after the later start and carries the later result.
- R7: The quotient bit q = (S[0] + C[0] + x_k·Y[0]) mod 2 selects the addend with {x_k, q} as a 2-bit code: 00 adds 0, 01 adds N, 10 adds Y and 11 adds Y+N. The three-input sum of each iteration is even, so halving it drops no set bit.
- R8: If X or Y is zero, both result words are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads the operands and clears the accumulator |
| x_i | input | NB | Multiplier operand X, scanned LSB first |
| y_i | input | NB | Multiplicand operand Y |
| mod_i | input | NB | Odd modulus N |
| ypn_i | input | NB+1 | Precomputed Y+N |
| carry_o | output | NB+2 | Carry word of the result |
| sum_o | output | NB+2 | Sum word of the result |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench builds the block with NB = 8. At this width every odd modulus below 64 meets the 4N < 2^n rule, and n + 4 cycles per product keep large sweeps cheap. The sweep covers every X and Y below 2N for the moduli 3 and 13, and a strided grid of X and Y for 63, the largest allowed modulus. Each product is checked against the value predicted from the modular inverse of 2^n, against the 2N bound and against the exact done cycle. Separate cases cover zero operands, a restart part-way through an operation and the result holding after done.

// File: rtl/mm_cs_pkg.sv
package mm_cs_pkg;

    // Addend choice, encoded as {x_k, q}
    typedef enum logic [1:0] {
        ADD_NONE = 2'b00,
        ADD_MOD  = 2'b01,
        ADD_OPY  = 2'b10,
        ADD_BOTH = 2'b11
    } addend_e;

    typedef struct packed {
        logic    q;
        addend_e pick;
    } qdec_t;

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Quotient bit and addend choice for one iteration
    function automatic qdec_t decide(input logic s0, input logic c0,
                                     input logic xk, input logic y0);
        qdec_t d;
        d.q    = s0 ^ c0 ^ (xk & y0);
        d.pick = addend_e'({xk, d.q});
        return d;
    endfunction

endpackage

// File: rtl/mm_cs_qpe.sv
module mm_cs_qpe
    import mm_cs_pkg::*;
#(
    parameter int NB = 8,
    localparam int WB = NB + 2
) (
    input  logic          s0_i,
    input  logic          c0_i,
    input  logic          xk_i,
    input  logic [NB-1:0] y_i,
    input  logic [NB-1:0] mod_i,
    input  logic [NB:0]   ypn_i,
    output logic [WB-1:0] addend_o
);

    qdec_t dec;

    always_comb begin
        dec = decide(s0_i, c0_i, xk_i, y_i[0]);
        unique case (dec.pick)
            ADD_NONE: addend_o = '0;
            ADD_MOD:  addend_o = {2'b00, mod_i};
            ADD_OPY:  addend_o = {2'b00, y_i};
            ADD_BOTH: addend_o = {1'b0, ypn_i};
            default:  addend_o = '0;
        endcase
    end

endmodule

// File: rtl/mm_cs_row.sv
module mm_cs_row
    import mm_cs_pkg::*;
#(
    parameter int WB = 10
) (
    input  logic [WB-1:0] c_i,
    input  logic [WB-1:0] s_i,
    input  logic [WB-1:0] a_i,
    output logic [WB-1:0] c_o,
    output logic [WB-1:0] s_o,
    output logic          lsb_o
);

    logic [WB-1:0] psum;
    logic [WB-1:0] pcar;

    // One processing element per bit: full adder, then the halving shift
    for (genvar i = 0; i < WB; i++) begin : g_pe
        always_comb begin
            psum[i] = fa_sum(c_i[i], s_i[i], a_i[i]);
            pcar[i] = fa_carry(c_i[i], s_i[i], a_i[i]);
        end
        // carry of weight 2^(i+1) becomes weight 2^i after halving
        assign c_o[i] = pcar[i];
        if (i < WB - 1) begin : g_mid
            assign s_o[i] = psum[i+1];
        end else begin : g_top
            assign s_o[i] = 1'b0;
        end
    end

    assign lsb_o = psum[0];

endmodule

// File: rtl/mm_cs_seq.sv
module mm_cs_seq #(
    parameter int NB = 8,
    localparam int CW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic step_o,
    output logic done_o
);

    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == CW'(NB - 1)) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign step_o = busy && !start_i;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CW'(NB - 1)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !done_o);

endmodule

// File: rtl/mm_cs_montmul.sv
module mm_cs_montmul #(
    parameter int NB = 8,
    localparam int WB = NB + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [NB-1:0] x_i,
    input  logic [NB-1:0] y_i,
    input  logic [NB-1:0] mod_i,
    input  logic [NB:0]   ypn_i,
    output logic [WB-1:0] carry_o,
    output logic [WB-1:0] sum_o,
    output logic          done_o
);

    logic [NB-1:0] x_sr;
    logic [NB-1:0] y_q;
    logic [NB-1:0] m_q;
    logic [NB:0]   ypn_q;
    logic [WB-1:0] c_q, s_q;
    logic [WB-1:0] c_nx, s_nx;
    logic [WB-1:0] addend;
    logic          step;
    logic          lsb;

    mm_cs_seq #(.NB(NB)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .step_o  (step),
        .done_o  (done_o)
    );

    mm_cs_qpe #(.NB(NB)) u_qpe (
        .s0_i     (s_q[0]),
        .c0_i     (c_q[0]),
        .xk_i     (x_sr[0]),
        .y_i      (y_q),
        .mod_i    (m_q),
        .ypn_i    (ypn_q),
        .addend_o (addend)
    );

    mm_cs_row #(.WB(WB)) u_row (
        .c_i   (c_q),
        .s_i   (s_q),
        .a_i   (addend),
        .c_o   (c_nx),
        .s_o   (s_nx),
        .lsb_o (lsb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_sr  <= '0;
            y_q   <= '0;
            m_q   <= '0;
            ypn_q <= '0;
            c_q   <= '0;
            s_q   <= '0;
        end else if (start_i) begin
            x_sr  <= x_i;
            y_q   <= y_i;
            m_q   <= mod_i;
            ypn_q <= ypn_i;
            c_q   <= '0;
            s_q   <= '0;
        end else if (step) begin
            x_sr  <= x_sr >> 1;
            c_q   <= c_nx;
            s_q   <= s_nx;
        end
    end

    assign carry_o = c_q;
    assign sum_o   = s_q;

    // R7: the quotient choice makes each three-input sum even
    // R7
    even_sum_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> !lsb);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done_o && c_q == '0 && s_q == '0));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(c_q) && $stable(s_q)));

    // R8: a zero multiplier keeps the accumulator at zero
    // R8
    zero_x_chk: assert property (@(posedge clk) disable iff (rst)
        (step && x_sr == '0 && c_q == '0 && s_q == '0) |=> (c_q == '0 && s_q == '0));

endmodule

// File: tb/sim_mm_cs_montmul.sv
`timescale 1ns/1ps
module sim_mm_cs_montmul;

    localparam int NB = 8;
    localparam int WB = NB + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB-1:0] x = '0, y = '0, m = '0;
    logic [NB:0]   ypn = '0;
    logic [WB-1:0] carry, sum;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mm_cs_montmul #(.NB(NB)) u0 (
        .clk(clk), .rst(rst), .start_i(start),
        .x_i(x), .y_i(y), .mod_i(m), .ypn_i(ypn),
        .carry_o(carry), .sum_o(sum), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expect_mont(input longint xv, input longint yv, input longint mv);
        longint half = (mv + 1) / 2;
        longint inv = 1;
        for (int i = 0; i < NB; i++) inv = (inv * half) % mv;
        return (((xv * yv) % mv) * inv) % mv;
    endfunction

    // called just after a negedge
    task automatic launch(input int xv, input int yv, input int mv);
        x = NB'(xv); y = NB'(yv); m = NB'(mv); ypn = (NB+1)'(yv + mv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish(input int xv, input int yv, input int mv);
        int hits = 0;
        int at = -1;
        longint v;
        logic [WB-1:0] c_cap, s_cap;
        bit stable = 1;
        bit quiet = 1;
        for (int k = 1; k <= NB; k++) begin
            @(negedge clk);
            if (done) begin hits++; at = k; end
        end
        // R4: done exactly once, NB cycles after start
        chk(hits == 1 && at == NB, "R4", "done cycle", at, NB);
        v = longint'(carry) + longint'(sum);
        chk((v % mv) == expect_mont(xv, yv, mv), "R2", "residue", v % mv, expect_mont(xv, yv, mv));
        chk(v < 2 * mv, "R3", "below 2N", v, 2 * mv);
        if (xv == 0 || yv == 0)
            chk(carry == '0 && sum == '0, "R8", "zero operand", v, 0);
        c_cap = carry; s_cap = sum;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (carry != c_cap || sum != s_cap) stable = 0;
            if (done) quiet = 0;
        end
        // R5: hold after done
        chk(stable && quiet, "R5", "hold after done", longint'(carry) + longint'(sum), v);
    endtask

    task automatic mul(input int xv, input int yv, input int mv);
        launch(xv, yv, mv);
        finish(xv, yv, mv);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(!done && carry == '0 && sum == '0, "R1", "in reset", longint'(carry) + longint'(sum), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && carry == '0 && sum == '0, "R1", "after reset", longint'(done), 0);

        // R8 corner cases
        mul(0, 25, 13);
        mul(17, 0, 13);
        mul(0, 0, 63);

        // R2 R3 R7: exhaustive for small moduli
        for (int xv = 0; xv < 6; xv++)
            for (int yv = 0; yv < 6; yv++) mul(xv, yv, 3);
        for (int xv = 0; xv < 26; xv++)
            for (int yv = 0; yv < 26; yv++) mul(xv, yv, 13);
        // largest modulus allowed at NB=8: strided grid plus extremes
        for (int xv = 0; xv < 126; xv += 5)
            for (int yv = 0; yv < 126; yv += 5) mul(xv, yv, 63);
        mul(125, 125, 63);
        mul(1, 1, 63);

        // R6: restart while busy
        begin
            bit early = 0;
            launch(100, 90, 61);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (done) early = 1;
            end
            chk(!early, "R6", "no done from aborted op", longint'(early), 0);
            launch(7, 40, 29);
            finish(7, 40, 29);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule